// File: doc/BRIEF.md
# Keyed Watchdog Timer with Configurable Reset Pulse

This block is a memory-mapped watchdog. A 32-bit down-counter is loaded from a reload register and decrements once per cycle in which the `tick_1us` enable is high, so the reload value is a time in microseconds. Software keeps the system alive by writing a 16-bit key to a restart register. If it stops doing so, the counter runs out. The block then raises an interrupt, drives a reset pulse of programmable length, or does both. An external memory-reset-hold input can veto the action; in that case the block disables itself instead.

The reset pulse can be active high or active low. It can drive the pin at all times (push-pull) or only while active (open-drain). These two properties change only when a matching key byte is written into the top byte of the width register, so an ordinary width update cannot flip them. The control register accepts a write only when the write changes the enable bit.

Internally, a four-state machine controls the counter:
- States: `ST_IDLE` (disabled), `ST_COUNT` (counting down), `ST_PULSE` (reset pulse active) and `ST_DONE` (expired, counter parked at zero).
- Transitions from `ST_IDLE`: *enable-rise* goes to `ST_COUNT`.
- Transitions from `ST_COUNT`: *expire-pulse* goes to `ST_PULSE`, *expire-quiet* goes to `ST_DONE`, and *expire-held* goes to `ST_IDLE`.
- Transitions from `ST_PULSE`: *pulse-end* goes to `ST_DONE`.
- Transitions from any enabled state: *restart* goes to `ST_COUNT` and *enable-fall* goes to `ST_IDLE`.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, status (0x00) and reload (0x04) read 0x03EF1480, control (0x0C) reads 0 and width (0x18) reads 0x000000FF. Reads of the restart register (0x08), of unmapped offsets or of offsets with addr[1:0] != 0 return 0.
- R2: A write to 0x08 whose data bits 15:0 equal 0x4755 loads the counter from reload and clears the interrupt. If the block is enabled, counting resumes. A write with any other low half changes nothing.
- R3: Control bit 0 is enable, bit 1 is reset-system, bit 2 is interrupt enable; bits 3, 4 and 6:5 are stored only. A control write is stored only if it changes bit 0. A 0-to-1 write loads the counter from reload and starts counting. A 1-to-0 write stops counting, and the counter holds its value.
- R4: While counting, each tick decrements the counter. On a tick when the counter is 1 or 0, the counter becomes 0 and stays there, and the block expires.
- R5: A width write always copies data bits 19:0 into the pulse-width field. When data bits 31:24 are 0xA5, bit 31 (active high) is set; 0x5A clears it. When they are 0xA8, bit 30 (push-pull) is set; 0x8A clears it. No other bit changes.
- R6: If `mem_rst_hold` is 1 at expiry, the control register becomes 0, counting stops, and neither the pulse nor the interrupt occurs.
- R7: If control bit 2 is set at an unheld expiry, `wdt_irq` rises on the next cycle. It stays high until a restart (R2) or an enable 0-to-1 write.
- R8: If control bit 1 is set and the width field is nonzero at an unheld expiry, the pulse is active from the next cycle for exactly width-field ticks. While the pulse is active, `wdt_rst` equals bit 31; otherwise it equals the inverse of bit 31. `wdt_rst_oe` is always 1 when bit 30 is 1, and only during the pulse when bit 30 is 0.
- R9: A restart or enable-changing write takes priority over a tick in the same cycle. That tick neither decrements nor expires the counter.
- R10: Writes to the status register and to misaligned addresses have no effect. The register at 0x1C reads back what was written to it and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | Count enable, one pulse per microsecond |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| mem_rst_hold | input | 1 | Suppresses the expiry action when high |
| wdt_rst | output | 1 | Reset pulse level |
| wdt_rst_oe | output | 1 | Output enable for the reset pin |
| wdt_irq | output | 1 | Expiry interrupt |

## Verification
Two events can fall in the same cycle: a bus write that restarts or re-enables the counter, and the tick that would expire it. The bench turns off its free-running tick and counts the counter down by hand to 1. It then drives the final tick and the keyed restart write in the same cycle. The check passes only if the counter reads back the reload value, the interrupt stays low and no pulse appears. A later tick must then decrement from the reload value.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_PULSE = 2'd2,
        ST_DONE  = 2'd3
    } wdk_state_e;

    localparam int unsigned OFS_STATUS  = 32'h00;
    localparam int unsigned OFS_RELOAD  = 32'h04;
    localparam int unsigned OFS_RESTART = 32'h08;
    localparam int unsigned OFS_CTRL    = 32'h0C;
    localparam int unsigned OFS_WIDTH   = 32'h18;
    localparam int unsigned OFS_MASK    = 32'h1C;

    localparam logic [15:0] RESTART_KEY = 16'h4755;
    localparam logic [7:0]  KEY_HIGH    = 8'hA5;
    localparam logic [7:0]  KEY_LOW     = 8'h5A;
    localparam logic [7:0]  KEY_PP      = 8'hA8;
    localparam logic [7:0]  KEY_OD      = 8'h8A;

    localparam logic [31:0] RELOAD_RST  = 32'h03EF1480;
    localparam logic [31:0] WIDTH_RST   = 32'h000000FF;

endpackage

// File: rtl/wdk_regs.sv
module wdk_regs
    import wdk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int PW_W   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clr_ctrl,
    input  logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] reload,
    output logic [DATA_W-1:0] ctrl,
    output logic [PW_W-1:0]   pulse_w,
    output logic              act_high,
    output logic              push_pull,
    output logic              ev_restart,
    output logic              ev_rise,
    output logic              ev_fall
);
    localparam int HI = DATA_W - 1;
    localparam int LO = DATA_W - 8;

    logic              aligned;
    logic              hit_reload, hit_restart, hit_ctrl, hit_width, hit_mask;
    logic [DATA_W-1:0] reload_q, ctrl_q, width_q, mask_q;

    assign aligned     = (addr[1:0] == 2'b00);
    assign hit_reload  = wr && aligned && (addr == ADDR_W'(OFS_RELOAD));
    assign hit_restart = wr && aligned && (addr == ADDR_W'(OFS_RESTART));
    assign hit_ctrl    = wr && aligned && (addr == ADDR_W'(OFS_CTRL));
    assign hit_width   = wr && aligned && (addr == ADDR_W'(OFS_WIDTH));
    assign hit_mask    = wr && aligned && (addr == ADDR_W'(OFS_MASK));

    assign ev_restart  = hit_restart && (wdata[15:0] == RESTART_KEY);
    assign ev_rise     = hit_ctrl && wdata[0] && !ctrl_q[0];
    assign ev_fall     = hit_ctrl && !wdata[0] && ctrl_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= DATA_W'(RELOAD_RST);
            ctrl_q   <= '0;
            width_q  <= DATA_W'(WIDTH_RST);
            mask_q   <= '0;
        end else begin
            if (hit_reload) reload_q <= wdata;
            if (clr_ctrl)                ctrl_q <= '0;
            else if (ev_rise || ev_fall) ctrl_q <= wdata;
            if (hit_mask)   mask_q <= wdata;
            if (hit_width) begin
                width_q[PW_W-1:0] <= wdata[PW_W-1:0];
                case (wdata[HI:LO])
                    KEY_HIGH: width_q[HI]   <= 1'b1;
                    KEY_LOW:  width_q[HI]   <= 1'b0;
                    KEY_PP:   width_q[HI-1] <= 1'b1;
                    KEY_OD:   width_q[HI-1] <= 1'b0;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            if      (addr == ADDR_W'(OFS_STATUS)) rdata = count;
            else if (addr == ADDR_W'(OFS_RELOAD)) rdata = reload_q;
            else if (addr == ADDR_W'(OFS_CTRL))   rdata = ctrl_q;
            else if (addr == ADDR_W'(OFS_WIDTH))  rdata = width_q;
            else if (addr == ADDR_W'(OFS_MASK))   rdata = mask_q;
        end
    end

    assign reload    = reload_q;
    assign ctrl      = ctrl_q;
    assign pulse_w   = width_q[PW_W-1:0];
    assign act_high  = width_q[HI];
    assign push_pull = width_q[HI-1];

endmodule

// File: rtl/wdk_core.sv
module wdk_core
    import wdk_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PW_W  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hold,
    input  logic             ev_restart,
    input  logic             ev_rise,
    input  logic             ev_fall,
    input  logic [CNT_W-1:0] reload,
    input  logic             irq_en,
    input  logic             rst_sys,
    input  logic [PW_W-1:0]  pulse_w,
    output logic [CNT_W-1:0] count,
    output wdk_state_e       state,
    output logic             irq,
    output logic             pulse_act,
    output logic             expire,
    output logic             clr_ctrl
);
    wdk_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic [PW_W-1:0]  pcnt_q, pcnt_d;
    logic             irq_q, irq_d;
    logic             bus_ev;
    logic             last_tick;

    assign bus_ev    = ev_restart || ev_rise || ev_fall;
    assign last_tick = (count_q <= CNT_W'(1));

    // next-state and datapath
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        pcnt_d  = pcnt_q;
        irq_d   = irq_q;
        if (ev_rise) begin
            state_d = ST_COUNT;
            count_d = reload;
            irq_d   = 1'b0;
        end else if (ev_fall) begin
            state_d = ST_IDLE;
        end else if (ev_restart) begin
            count_d = reload;
            irq_d   = 1'b0;
            if (state_q != ST_IDLE) state_d = ST_COUNT;
        end else if (tick) begin
            unique case (state_q)
                ST_COUNT: begin
                    if (last_tick) begin
                        count_d = '0;
                        if (hold) begin
                            state_d = ST_IDLE;
                        end else begin
                            if (irq_en) irq_d = 1'b1;
                            if (rst_sys && (pulse_w != '0)) begin
                                state_d = ST_PULSE;
                                pcnt_d  = pulse_w;
                            end else begin
                                state_d = ST_DONE;
                            end
                        end
                    end else begin
                        count_d = count_q - CNT_W'(1);
                    end
                end
                ST_PULSE: begin
                    if (pcnt_q == PW_W'(1)) state_d = ST_DONE;
                    else                     pcnt_d  = pcnt_q - PW_W'(1);
                end
                ST_IDLE, ST_DONE: ;
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            count_q <= CNT_W'(RELOAD_RST);
            pcnt_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            pcnt_q  <= pcnt_d;
            irq_q   <= irq_d;
        end
    end

    // outputs
    always_comb begin
        expire    = (state_q == ST_COUNT) && tick && last_tick && !bus_ev;
        clr_ctrl  = expire && hold;
        pulse_act = (state_q == ST_PULSE);
        count     = count_q;
        state     = state_q;
        irq       = irq_q;
    end

endmodule

// File: rtl/wdk_drive.sv
module wdk_drive (
    input  logic pulse_act,
    input  logic act_high,
    input  logic push_pull,
    output logic rst_level,
    output logic rst_oe
);
    always_comb begin
        rst_level = act_high ? pulse_act : !pulse_act;
        rst_oe    = push_pull || pulse_act;
    end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int PW_W   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1us,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              mem_rst_hold,
    output logic              wdt_rst,
    output logic              wdt_rst_oe,
    output logic              wdt_irq
);
    logic [DATA_W-1:0] count_w, reload_w, ctrl_w;
    logic [PW_W-1:0]   pulse_w;
    logic              act_high_w, push_pull_w;
    logic              ev_restart, ev_rise, ev_fall;
    logic              clr_ctrl_w, expire_w, pulse_act_w;
    wdk_state_e        state_w;

    wdk_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PW_W(PW_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .clr_ctrl(clr_ctrl_w), .count(count_w),
        .rdata(bus_rdata), .reload(reload_w), .ctrl(ctrl_w),
        .pulse_w(pulse_w), .act_high(act_high_w), .push_pull(push_pull_w),
        .ev_restart(ev_restart), .ev_rise(ev_rise), .ev_fall(ev_fall)
    );

    wdk_core #(.CNT_W(DATA_W), .PW_W(PW_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick_1us), .hold(mem_rst_hold),
        .ev_restart(ev_restart), .ev_rise(ev_rise), .ev_fall(ev_fall),
        .reload(reload_w), .irq_en(ctrl_w[2]), .rst_sys(ctrl_w[1]),
        .pulse_w(pulse_w), .count(count_w), .state(state_w), .irq(wdt_irq),
        .pulse_act(pulse_act_w), .expire(expire_w), .clr_ctrl(clr_ctrl_w)
    );

    wdk_drive u_drive (
        .pulse_act(pulse_act_w), .act_high(act_high_w), .push_pull(push_pull_w),
        .rst_level(wdt_rst), .rst_oe(wdt_rst_oe)
    );

endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk
    import wdk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold,
    input logic              ev_restart,
    input logic              ev_rise,
    input wdk_state_e        state,
    input logic [DATA_W-1:0] ctrl,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W-1:0] reload,
    input logic              expire,
    input logic              irq,
    input logic              pulse_act,
    input logic              act_high,
    input logic              push_pull,
    input logic              rst_out,
    input logic              rst_oe
);
    assert_enable_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[0] == (state != ST_IDLE));

    assert_restart_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_restart |=> count == $past(reload));

    assert_no_count_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count > $past(count)) |-> ($past(ev_restart) || $past(ev_rise)));

    assert_hold_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && hold) |=> (ctrl == '0) && !irq && !pulse_act);

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ctrl[2]) && $past(expire));

    assert_od_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_oe && !push_pull) |-> (rst_out == act_high));
endmodule

bind wdog_keyed wdog_keyed_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hold(mem_rst_hold), .ev_restart(ev_restart),
    .ev_rise(ev_rise), .state(state_w), .ctrl(ctrl_w), .count(count_w),
    .reload(reload_w), .expire(expire_w), .irq(wdt_irq),
    .pulse_act(pulse_act_w), .act_high(act_high_w), .push_pull(push_pull_w),
    .rst_out(wdt_rst), .rst_oe(wdt_rst_oe)
);

// File: tb/tb_wdog_keyed.sv
module tb_wdog_keyed;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mem_rst_hold = 1'b0;
    logic        wdt_rst, wdt_rst_oe, wdt_irq;
    logic        tick_auto = 1'b1;
    logic        tick_gen = 1'b0;
    logic        tick_man = 1'b0;
    logic        tick_1us;
    int          tdiv = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    bit          done = 0;
    string       tag = "R1";

    // reference model state
    bit [31:0] m_count, m_reload, m_ctrl, m_width, m_mask;
    int        m_state;   // 0 idle, 1 count, 2 pulse, 3 done
    int        m_pcnt;
    bit        m_irq;

    always #4 clk = ~clk;
    assign tick_1us = tick_auto ? tick_gen : tick_man;

    wdog_keyed dut (
        .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mem_rst_hold(mem_rst_hold), .wdt_rst(wdt_rst),
        .wdt_rst_oe(wdt_rst_oe), .wdt_irq(wdt_irq)
    );

    always @(negedge clk) begin
        tdiv     <= tdiv + 1;
        tick_gen <= ((tdiv % 3) == 0);
    end

    function automatic bit [31:0] exp_rd(bit [7:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        case (a)
            8'h00:   return m_count;
            8'h04:   return m_reload;
            8'h0C:   return m_ctrl;
            8'h18:   return m_width;
            8'h1C:   return m_mask;
            default: return 32'h0;
        endcase
    endfunction

    // behavioural model, updated on every edge
    always @(posedge clk) begin
        bit al, rs, ri, fa;
        if (!rst_n) begin
            m_count = 32'h03EF1480; m_reload = 32'h03EF1480; m_ctrl = 0;
            m_width = 32'hFF; m_mask = 0; m_state = 0; m_pcnt = 0; m_irq = 0;
        end else begin
            al = bus_wr && (bus_addr[1:0] == 2'b00);
            rs = al && bus_addr == 8'h08 && bus_wdata[15:0] == 16'h4755;
            ri = al && bus_addr == 8'h0C && bus_wdata[0] && !m_ctrl[0];
            fa = al && bus_addr == 8'h0C && !bus_wdata[0] && m_ctrl[0];
            if (ri) begin
                m_ctrl = bus_wdata; m_count = m_reload; m_state = 1; m_irq = 0;
            end else if (fa) begin
                m_ctrl = bus_wdata; m_state = 0;
            end else if (rs) begin
                m_count = m_reload; m_irq = 0;
                if (m_state != 0) m_state = 1;
            end else if (tick_1us) begin
                if (m_state == 1) begin
                    if (m_count <= 1) begin
                        m_count = 0;
                        if (mem_rst_hold) begin
                            m_ctrl = 0; m_state = 0;
                        end else begin
                            if (m_ctrl[2]) m_irq = 1;
                            if (m_ctrl[1] && m_width[19:0] != 0) begin
                                m_state = 2; m_pcnt = int'(m_width[19:0]);
                            end else m_state = 3;
                        end
                    end else m_count = m_count - 1;
                end else if (m_state == 2) begin
                    if (m_pcnt == 1) m_state = 3;
                    else m_pcnt = m_pcnt - 1;
                end
            end
            if (al && bus_addr == 8'h04) m_reload = bus_wdata;
            if (al && bus_addr == 8'h1C) m_mask = bus_wdata;
            if (al && bus_addr == 8'h18) begin
                m_width[19:0] = bus_wdata[19:0];
                if (bus_wdata[31:24] == 8'hA5) m_width[31] = 1;
                if (bus_wdata[31:24] == 8'h5A) m_width[31] = 0;
                if (bus_wdata[31:24] == 8'hA8) m_width[30] = 1;
                if (bus_wdata[31:24] == 8'h8A) m_width[30] = 0;
            end
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        bit pa;
        #2;
        if (rst_n && !done) begin
            pa = (m_state == 2);
            chk(tag, "rdata", bus_rdata, exp_rd(bus_addr));
            chk("R7", "irq", 32'(wdt_irq), 32'(m_irq));
            chk("R8", "rst", 32'(wdt_rst), 32'(m_width[31] ? pa : !pa));
            chk("R8", "rst_oe", 32'(wdt_rst_oe), 32'(m_width[30] | pa));
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    task automatic wr(bit [7:0] a, bit [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_addr = 8'h00; bus_wdata = 0;
    endtask

    task automatic rd_chk(string req, bit [7:0] a, bit [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, "read", bus_rdata, exp);
        @(negedge clk);
        bus_addr = 8'h00;
    endtask

    task automatic watch(int n, output int hi_cyc, output int oe_cyc, output int lo_cyc);
        hi_cyc = 0; oe_cyc = 0; lo_cyc = 0;
        repeat (n) begin
            @(negedge clk);
            if (wdt_rst) hi_cyc++; else lo_cyc++;
            if (wdt_rst_oe) oe_cyc++;
        end
    endtask

    task automatic man_tick(bit with_restart);
        @(negedge clk);
        tick_man = 1;
        if (with_restart) begin
            bus_wr = 1; bus_addr = 8'h08; bus_wdata = 32'h00004755;
        end
        @(negedge clk);
        tick_man = 0; bus_wr = 0; bus_addr = 8'h00; bus_wdata = 0;
    endtask

    initial begin
        int hi, oe, lo;
        bit [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        tag = "R1";
        rd_chk("R1", 8'h00, 32'h03EF1480);
        rd_chk("R1", 8'h04, 32'h03EF1480);
        rd_chk("R1", 8'h0C, 32'h0);
        rd_chk("R1", 8'h18, 32'hFF);
        rd_chk("R1", 8'h08, 32'h0);
        rd_chk("R1", 8'h10, 32'h0);
        rd_chk("R1", 8'h06, 32'h0);
        chk("R1", "idle rst", 32'(wdt_rst), 32'h1);
        chk("R1", "idle oe", 32'(wdt_rst_oe), 32'h0);
        // R10 ignored writes and the plain register
        tag = "R10";
        wr(8'h00, 32'h5);
        rd_chk("R10", 8'h00, 32'h03EF1480);
        wr(8'h05, 32'h1);
        rd_chk("R10", 8'h04, 32'h03EF1480);
        wr(8'h1C, 32'h1234ABCD);
        rd_chk("R10", 8'h1C, 32'h1234ABCD);
        rd_chk("R10", 8'h00, 32'h03EF1480);
        // R5 key bytes
        tag = "R5";
        wr(8'h04, 32'd10);
        wr(8'h18, 32'hA5000004);
        rd_chk("R5", 8'h18, 32'h80000004);
        wr(8'h18, 32'h12FFF003);
        rd_chk("R5", 8'h18, 32'h800FF003);
        wr(8'h18, 32'hA8000003);
        rd_chk("R5", 8'h18, 32'hC0000003);
        // R3 enable and ignored control write
        tag = "R3";
        wr(8'h0C, 32'h07);
        wr(8'h0C, 32'h05);
        rd_chk("R3", 8'h0C, 32'h07);
        // R4 and R8: expiry with active-high push-pull pulse of 3 ticks
        tag = "R4";
        watch(70, hi, oe, lo);
        chk("R8", "active-high cycles", hi, 9);
        chk("R8", "push-pull oe cycles", oe, 70);
        chk("R7", "irq after expiry", 32'(wdt_irq), 32'h1);
        rd_chk("R4", 8'h00, 32'h0);
        // R2 wrong key then right key
        tag = "R2";
        wr(8'h08, 32'h00004756);
        chk("R2", "irq after wrong key", 32'(wdt_irq), 32'h1);
        rd_chk("R2", 8'h00, 32'h0);
        wr(8'h08, 32'hABCD4755);
        chk("R2", "irq after key", 32'(wdt_irq), 32'h0);
        // R3 disable holds the count
        tag = "R3";
        wr(8'h0C, 32'h06);
        @(negedge clk); bus_addr = 8'h00; #1; held = bus_rdata;
        repeat (20) @(negedge clk);
        rd_chk("R3", 8'h00, held);
        // R8: active-low open-drain pulse of 2 ticks, no interrupt
        tag = "R8";
        wr(8'h18, 32'h5A000002);
        wr(8'h18, 32'h8A000002);
        rd_chk("R5", 8'h18, 32'h00000002);
        wr(8'h0C, 32'h03);
        watch(60, hi, oe, lo);
        chk("R8", "open-drain oe cycles", oe, 6);
        chk("R8", "active-low cycles", lo, 6);
        chk("R7", "irq masked", 32'(wdt_irq), 32'h0);
        // R6 hold suppresses the action
        tag = "R6";
        wr(8'h0C, 32'h02);
        mem_rst_hold = 1;
        wr(8'h0C, 32'h07);
        watch(60, hi, oe, lo);
        chk("R6", "no pulse oe", oe, 0);
        chk("R6", "no irq", 32'(wdt_irq), 32'h0);
        rd_chk("R6", 8'h0C, 32'h0);
        mem_rst_hold = 0;
        // R9 restart and final tick in the same cycle
        tag = "R9";
        tick_auto = 0;
        wr(8'h04, 32'd3);
        wr(8'h0C, 32'h07);
        man_tick(0);
        man_tick(0);
        rd_chk("R9", 8'h00, 32'd1);
        man_tick(1);
        rd_chk("R9", 8'h00, 32'd3);
        chk("R9", "no irq", 32'(wdt_irq), 32'h0);
        man_tick(0);
        rd_chk("R9", 8'h00, 32'd2);
        repeat (3) @(negedge clk);
        summary();
    end
endmodule